// File: doc/BRIEF.md
# Asynchronous byte-lane SRAM controller

This block sits between an internal request port and an external asynchronous static RAM that has a 16-bit data word, an 18-bit word address and one active-low enable per byte lane. Each accepted request is a single word. It is either a write, which stores only the lanes selected by a per-byte mask, or a read, which returns only the selected lanes and sets the unselected ones to zero. The controller has one clock. It turns the memory's nanosecond timing limits into whole-cycle phase lengths when it is elaborated. The clock period and every timing limit are parameters.

On the memory side there are registered, active-low select, write-strobe, output-enable and byte-enable pins. The data bus is split into an outgoing word, an outgoing-enable and an incoming word, and together these stand in for a tristate pad. In a write, the strobe pulse stays low long enough to cover the memory's bus-release time and then the data setup. Data is driven only after the memory has released the bus, and it is held through the rising edge of the strobe. In a read, select and output-enable stay low for the access time, and the word is captured in the last cycle. After every read, one or more quiet cycles follow so that the memory can stop driving. After reset, no access starts until the power-up wait has passed.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and on the first edge after it is released, mem_ce_n, mem_we_n, mem_oe_n and every bit of mem_be_n are 1, and mem_dq_oe, req_ready and rsp_valid are 0.
- R2: req_ready first reads 1 after exactly ceil(T_PWR_NS/CLK_NS) rising edges following the release of reset, and it stays 0 before that.
- R3: A request is taken on an edge where req_valid and req_ready are both 1. req_ready is 1 only when the controller is idle with the memory deselected. After a write is taken, req_ready stays 0 for SETUP+PULSE+1 cycles.
- R4: A write holds mem_ce_n low with mem_we_n high for SETUP = ceil(T_AS_NS/CLK_NS) cycles (at least 1). It then holds mem_we_n low for PULSE = max(ceil(T_PWE_NS/CLK_NS), REL+ceil(T_SD_NS/CLK_NS)) cycles. Then follows one cycle with mem_we_n high and mem_ce_n still low, after which the memory is deselected.
- R5: mem_dq_oe is 1 only in a write. It rises after mem_we_n has been low for REL = ceil(T_HZWE_NS/CLK_NS) cycles, stays 1 through the cycle in which mem_we_n rises, and never overlaps a cycle in which the memory may be driving.
- R6: For the whole access, mem_be_n[i] equals the inverse of req_mask[i]. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A lane whose mask bit is 0 is left unchanged by a write, so a write with mask 00 changes nothing.
- R7: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for READ = ceil(max(T_AA_NS,T_DOE_NS)/CLK_NS) cycles and captures mem_dq_in on the last of them. rsp_valid is 1 for exactly the next cycle, and rsp_rdata carries the selected lanes with the other lanes zero.
- R8: After a read, all controls are inactive and req_ready is 0 for TURN = ceil(T_HZOE_NS/CLK_NS) cycles. A read therefore keeps req_ready at 0 for READ+TURN cycles.
- R9: mem_addr and mem_be_n do not change while mem_ce_n stays low.
- R10: mem_oe_n is 1 whenever mem_we_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_mask | input | LANES | Lane select, bit i covers bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | DATA_W | Read word, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Byte-lane enables, active low |
| mem_dq_out | output | DATA_W | Outgoing data word |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Incoming data word |

## Verification
A wrong phase count or a skipped state shows at the pins within the same access. The strobe pulse would be too short, the data drive would start before the release window, or the strobe would rise with the bus undriven, and the memory model counts each of these on the edge where it happens. A wrong lane mask or a capture in the wrong cycle shows as a wrong word on the next read of that address, about four cycles later, because the model returns filler bytes on disabled lanes and before the access time has passed. A broken turnaround shows as the two sides driving the bus in the same cycle, or as req_ready coming back one cycle too early.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WSET,
    ST_WREL,
    ST_WDRV,
    ST_WEND,
    ST_RACC,
    ST_RTURN
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic lanes_on;
    logic drive;
  } pin_ctl_t;

  // Whole cycles covering a time in ns, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels held during each phase.
  function automatic pin_ctl_t phase_pins(input phase_e ph);
    pin_ctl_t p;
    p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
    case (ph)
      ST_WSET: begin p.ce_n = 1'b0; p.lanes_on = 1'b1; end
      ST_WREL: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.lanes_on = 1'b1; end
      ST_WDRV: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.lanes_on = 1'b1; p.drive = 1'b1; end
      ST_WEND: begin p.ce_n = 1'b0; p.lanes_on = 1'b1; p.drive = 1'b1; end
      ST_RACC: begin p.ce_n = 1'b0; p.oe_n = 1'b0; p.lanes_on = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_lane_pwrup.sv
module sram_lane_pwrup #(
  parameter int unsigned PWR_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic boot_done
);
  localparam int unsigned CW = (PWR_CYC > 1) ? $clog2(PWR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PWR_CYC - 1);

  logic [CW-1:0] wait_q;

  // Counts edges from reset release and holds at the last value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wait_q != LAST) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign boot_done = (wait_q == LAST);
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned REL_CYC   = 1,
  parameter int unsigned DRV_CYC   = 1,
  parameter int unsigned READ_CYC  = 2,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   boot_done,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_e phase_q,
  output phase_e phase_nx,
  output logic   acc_fire,
  output logic   rd_capture
);
  localparam int unsigned LONGEST =
    umax(umax(SETUP_CYC, REL_CYC), umax(umax(DRV_CYC, READ_CYC), TURN_CYC));
  localparam int unsigned CNT_W = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  logic [CNT_W-1:0] left_q;
  logic             phase_last;

  // Cycles left in a phase once it has begun.
  function automatic logic [CNT_W-1:0] span(input phase_e p);
    case (p)
      ST_WSET:  return CNT_W'(SETUP_CYC - 1);
      ST_WREL:  return CNT_W'(REL_CYC - 1);
      ST_WDRV:  return CNT_W'(DRV_CYC - 1);
      ST_RACC:  return CNT_W'(READ_CYC - 1);
      ST_RTURN: return CNT_W'(TURN_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  assign phase_last = (left_q == '0);
  assign acc_fire   = (phase_q == ST_IDLE) && req_valid;
  assign rd_capture = (phase_q == ST_RACC) && phase_last;

  always_comb begin
    phase_nx = phase_q;
    case (phase_q)
      ST_BOOT:  if (boot_done) phase_nx = ST_IDLE;
      ST_IDLE:  if (req_valid) phase_nx = req_write ? ST_WSET : ST_RACC;
      ST_WSET:  if (phase_last) phase_nx = ST_WREL;
      ST_WREL:  if (phase_last) phase_nx = ST_WDRV;
      ST_WDRV:  if (phase_last) phase_nx = ST_WEND;
      ST_WEND:  phase_nx = ST_IDLE;
      ST_RACC:  if (phase_last) phase_nx = ST_RTURN;
      ST_RTURN: if (phase_last) phase_nx = ST_IDLE;
      default:  phase_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_BOOT;
      left_q  <= '0;
    end else begin
      phase_q <= phase_nx;
      if (phase_nx != phase_q) begin
        left_q <= span(phase_nx);
      end else if (!phase_last) begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_nx,
  input  logic              acc_fire,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  mask_nx;
  logic [DATA_W-1:0] lane_bits;
  pin_ctl_t          pins_nx;

  assign mask_nx = acc_fire ? req_mask : mask_q;
  assign pins_nx = phase_pins(phase_nx);

  // Spread each lane's mask bit across its byte.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{mask_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (acc_fire) begin
        mask_q     <= req_mask;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= pins_nx.ce_n;
      mem_we_n  <= pins_nx.we_n;
      mem_oe_n  <= pins_nx.oe_n;
      mem_be_n  <= pins_nx.lanes_on ? ~mask_nx : '1;
      mem_dq_oe <= pins_nx.drive;
      rsp_valid <= rd_capture;
      if (rd_capture) begin
        rsp_rdata <= mem_dq_in & lane_bits;
      end
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_PWE_NS  = 7,
  parameter int unsigned T_SD_NS   = 5,
  parameter int unsigned T_HZWE_NS = 5,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_DOE_NS  = 5,
  parameter int unsigned T_HZOE_NS = 5,
  parameter int unsigned T_PWR_NS  = 100000,
  localparam int unsigned LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned REL_CYC   = ns_to_cyc(T_HZWE_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = umax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                           REL_CYC + ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int unsigned DRV_CYC   = PULSE_CYC - REL_CYC;
  localparam int unsigned READ_CYC  = ns_to_cyc(umax(T_AA_NS, T_DOE_NS), CLK_NS);
  localparam int unsigned TURN_CYC  = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned PWR_CYC   = ns_to_cyc(T_PWR_NS, CLK_NS);

  // Internal events, named for the checker.
  logic   boot_done;
  logic   acc_fire;
  logic   rd_capture;
  phase_e phase_q;
  phase_e phase_nx;

  sram_lane_pwrup #(.PWR_CYC(PWR_CYC)) pwrup_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_done (boot_done)
  );

  sram_lane_seq #(
    .SETUP_CYC (SETUP_CYC),
    .REL_CYC   (REL_CYC),
    .DRV_CYC   (DRV_CYC),
    .READ_CYC  (READ_CYC),
    .TURN_CYC  (TURN_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_done  (boot_done),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_q    (phase_q),
    .phase_nx   (phase_nx),
    .acc_fire   (acc_fire),
    .rd_capture (rd_capture)
  );

  sram_lane_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) path_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_nx   (phase_nx),
    .acc_fire   (acc_fire),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  assign req_ready = (phase_q == ST_IDLE);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned LANES     = 2,
  parameter int unsigned PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic              mem_dq_oe,
  input logic              acc_fire,
  input logic              rd_capture
);
  int unsigned we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= 0;
    else if (!mem_we_n) we_run <= we_run + 1;
    else we_run <= 0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) &&
                      !mem_dq_oe && !req_ready && !rsp_valid));

  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_valid) |=> !req_ready);

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == PULSE_CYC));

  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  p_drive_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  p_drive_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_oe_n) == 1'b0));

  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_ce_n && !req_ready));

  p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  p_oe_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .PULSE_CYC (PULSE_CYC)
) chk_i (.*);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int NPOOL = 64;

  // Bench restatement of the phase lengths: smallest k>=1 with k*5 >= ns.
  function automatic int bcyc(input int ns);
    int k;
    k = 1;
    while (k * 5 < ns) k++;
    return k;
  endfunction

  localparam int SETUP_B = bcyc(0);
  localparam int REL_B   = bcyc(5);
  localparam int SD_B    = bcyc(5);
  localparam int PWE_B   = bcyc(7);
  localparam int PULSE_B = (PWE_B > REL_B + SD_B) ? PWE_B : REL_B + SD_B;
  localparam int READ_B  = bcyc(10);
  localparam int TURN_B  = bcyc(5);
  localparam int PWR_B   = bcyc(2000);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.T_PWR_NS(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pool_addr(input int i);
    if (i == NPOOL - 1) return {AW{1'b1}};
    return AW'(i * 4093);
  endfunction

  function automatic int pool_find(input logic [AW-1:0] a);
    for (int i = 0; i < NPOOL; i++) if (pool_addr(i) == a) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] lane_fill(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_m [NPOOL];
  logic [DW-1:0] ref_m [NPOOL];
  int rd_age = 0;
  int drv_tail = 0;
  int we_run = 0, drv_run = 0, set_run = 0;
  bit sel_prev = 0;
  logic [AW-1:0] addr_ref;
  logic [1:0] be_ref;
  int viol_tim = 0, viol_bus = 0, viol_stab = 0;

  initial for (int i = 0; i < NPOOL; i++) begin mem_m[i] = '0; ref_m[i] = '0; end

  always_comb begin
    int idx;
    logic [DW-1:0] word;
    idx = pool_find(mem_addr);
    word = (idx >= 0) ? mem_m[idx] : '0;
    for (int l = 0; l < 2; l++) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l] && rd_age >= READ_B - 1)
        mem_dq_in[l*8 +: 8] = word[l*8 +: 8];
      else
        mem_dq_in[l*8 +: 8] = (l == 0) ? 8'hC3 : 8'h3C;
    end
  end

  always @(posedge clk) begin
    bit rd_on, mdrive;
    int idx;
    if (rst_n) begin
      rd_on  = !mem_ce_n && !mem_oe_n && mem_we_n;
      mdrive = rd_on && (mem_be_n != 2'b11);
      rd_age <= rd_on ? rd_age + 1 : 0;
      if (mem_dq_oe && (mdrive || drv_tail > 0)) viol_bus++;
      if (mem_dq_oe && (mem_ce_n || !mem_oe_n)) viol_bus++;
      drv_tail <= mdrive ? TURN_B : ((drv_tail > 0) ? drv_tail - 1 : 0);
      if (!mem_ce_n && !sel_prev) begin
        addr_ref = mem_addr; be_ref = mem_be_n;
      end else if (!mem_ce_n && (mem_addr != addr_ref || mem_be_n != be_ref)) viol_stab++;
      if (!mem_ce_n && !mem_we_n) begin
        if (we_run == 0 && set_run < SETUP_B) viol_tim++;
        if (mem_dq_oe && we_run < REL_B) viol_bus++;
        if (mem_dq_oe) drv_run++;
        we_run++;
      end else if (we_run > 0) begin
        if (we_run < PWE_B) viol_tim++;
        if (drv_run < SD_B) viol_tim++;
        if (!mem_dq_oe) viol_bus++;
        idx = pool_find(mem_addr);
        if (idx >= 0)
          for (int l = 0; l < 2; l++)
            if (!mem_be_n[l]) mem_m[idx][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
        we_run = 0; drv_run = 0;
      end
      set_run  = (!mem_ce_n && mem_we_n) ? set_run + 1 : 0;
      sel_prev = !mem_ce_n;
    end
  end

  // ---------------- request tasks ----------------
  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input int idx, input logic [DW-1:0] d, input logic [1:0] m);
    int lowc, wel, drvc;
    bit oe_bad;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = pool_addr(idx); req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    lowc = 0; wel = 0; drvc = 0; oe_bad = 0;
    while (!req_ready) begin
      lowc++;
      if (!mem_we_n) wel++;
      if (mem_dq_oe) drvc++;
      if (!mem_we_n && !mem_oe_n) oe_bad = 1;
      if (!mem_ce_n && mem_be_n != ~m) oe_bad = 1;
      @(negedge clk);
    end
    chk(lowc == SETUP_B + PULSE_B + 1, "R3 write busy cycles", lowc, SETUP_B + PULSE_B + 1);
    chk(wel == PULSE_B, "R4 write strobe cycles", wel, PULSE_B);
    chk(drvc == PULSE_B - REL_B + 1, "R5 drive cycles", drvc, PULSE_B - REL_B + 1);
    chk(!oe_bad, "R10 R6 write pin levels", oe_bad, 0);
    for (int l = 0; l < 2; l++) if (m[l]) ref_m[idx][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic do_read(input int idx, input logic [1:0] m);
    int lowc, oel, vpos, vcnt;
    logic [DW-1:0] got, exp;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = pool_addr(idx); req_mask = m;
    @(negedge clk);
    req_valid = 0;
    lowc = 0; oel = 0; vpos = 0; vcnt = 0; got = '0;
    while (!req_ready) begin
      lowc++;
      if (!mem_oe_n) oel++;
      if (rsp_valid) begin vcnt++; vpos = lowc; got = rsp_rdata; end
      @(negedge clk);
    end
    if (rsp_valid) vcnt++;
    exp = ref_m[idx] & lane_fill(m);
    chk(lowc == READ_B + TURN_B, "R8 read busy cycles", lowc, READ_B + TURN_B);
    chk(oel == READ_B, "R7 read enable cycles", oel, READ_B);
    chk(vcnt == 1 && vpos == READ_B + 1, "R7 strobe timing", vpos, READ_B + 1);
    chk(got == exp, "R6 R7 read data", got, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    bit early;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe
        && !req_ready && !rsp_valid, "R1 reset pins",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid},
        32'b1111_1000);
    rst_n = 1;
    early = 0;
    for (int k = 1; k < PWR_B; k++) begin
      @(negedge clk);
      if (req_ready || !mem_ce_n) early = 1;
    end
    chk(!early, "R2 ready held low during wait", early, 0);
    @(negedge clk);
    chk(req_ready, "R2 ready after wait", req_ready, 1);

    // directed lane cases
    do_write(NPOOL - 1, 16'hFFFF, 2'b11);
    do_write(NPOOL - 1, 16'h1234, 2'b01);
    do_read (NPOOL - 1, 2'b11);
    do_write(NPOOL - 1, 16'hAB00, 2'b10);
    do_read (NPOOL - 1, 2'b11);
    do_write(NPOOL - 1, 16'h0000, 2'b00);
    do_read (NPOOL - 1, 2'b11);
    chk(ref_m[NPOOL - 1] == 16'hAB34, "R6 masked merge reference", ref_m[NPOOL - 1], 16'hAB34);
    do_read (NPOOL - 1, 2'b01);
    do_read (NPOOL - 1, 2'b10);
    do_read (NPOOL - 1, 2'b00);
    do_write(0, 16'h5AA5, 2'b11);
    do_read (0, 2'b11);
    do_write(0, 16'hC0DE, 2'b10);
    do_read (0, 2'b01);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int idx;
      logic [1:0] m;
      idx = int'($urandom % NPOOL);
      m = 2'($urandom % 4);
      if ($urandom % 2) do_write(idx, 16'($urandom), m);
      else do_read(idx, m);
    end

    // final sweep of every location with all lanes
    for (int i = 0; i < NPOOL; i++) do_read(i, 2'b11);

    repeat (4) @(negedge clk);
    chk(viol_tim == 0, "R4 model strobe timing", viol_tim, 0);
    chk(viol_bus == 0, "R5 model bus ownership", viol_bus, 0);
    chk(viol_stab == 0, "R9 model address hold", viol_stab, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule